// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point operands. Each word has a sign in bit 31, an 8-bit exponent with bias 127 in bits 30:23, and a 23-bit fraction in bits 22:0. A normal number carries an implied leading 1 ahead of the fraction. A select input turns the operation into a subtraction by inverting the sign of the second operand. The datapath has these steps:

- Unpack both operands.
- Align the smaller significand to the larger exponent, keeping guard, round and sticky bits.
- Add or subtract the significands.
- Normalize the sum.
- Round to nearest, ties to even.
- Normalize again when rounding carries out of the significand.

Infinities and NaNs are handled as special cases. Subnormal values are flushed to zero, both on the inputs and on the results. The whole computation is combinational and lands in a single output register. A result is therefore presented, tagged valid, on the cycle after its operands are accepted. One operation can be issued every cycle.

Top module: `fp_add_sp`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly the following cycle, carrying its result. While `out_valid` is low, `result`, `flag_invalid` and `flag_overflow` are all 0. Reset (active low) drives all outputs to 0.
- R2: For finite operands, the sum is computed with the smaller-exponent significand shifted right by the exponent difference. The result is the correctly rounded sum, including when the difference exceeds the significand width.
- R3: When `sub_sel` is 1, the result is `op_a` minus `op_b`. This is obtained by flipping the sign bit of `op_b` before the addition. A negative difference gives a set sign bit in bit 31.
- R4: Rounding is to nearest, with ties to even. The significand is incremented when the guard bit is 1 and either the round bit, the sticky bit or the result LSB is 1.
- R5: When rounding carries out of the 24-bit significand (all ones rounded up), the significand becomes 1.0 and the exponent is incremented by one.
- R6: Effective subtractions that cancel leading bits are normalized left, with the exponent lowered to match. An exactly zero result of an effective subtraction is +0 (0x00000000).
- R7: An operand whose exponent field is 0 is treated as zero of its sign. A result whose exponent would fall to 0 or below is flushed to a zero with the sign of the larger operand. No output ever has exponent field 0 with a non-zero fraction.
- R8: If either operand is a NaN (exponent field 255, fraction non-zero), the result is the quiet NaN 0x7FC00000.
- R9: An infinity (exponent field 255, fraction 0) combined with a finite value or with a like-signed infinity yields that infinity. Infinities of opposite effective sign yield 0x7FC00000 with `flag_invalid` set.
- R10: A rounded result exponent of 255 or more gives an infinity with the result's sign, with `flag_overflow` set. Both flags are 0 for every other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| sub_sel | input | 1 | 1 selects op_a minus op_b, 0 selects op_a plus op_b |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 32 | Rounded sum or difference |
| flag_invalid | output | 1 | Infinity minus infinity occurred |
| flag_overflow | output | 1 | Result rounded beyond the largest finite value |

## Verification
Every result is due exactly one rising edge after its operands are sampled, because the only storage on the path is the output register. The driver applies operands on a falling edge and queues the expected word and flags. The monitor samples on each following falling edge, so any result that arrives early, late or unrequested shows up as a mismatch against the queue. Idle cycles are inserted between bursts, which checks that the outputs return to zero when nothing is valid.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int EXT_W   = SIG_W + 3;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int LZ_W    = $clog2(EXT_W + 1);

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              zero;
        logic              inf;
        logic              nan;
    } fpa_op_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic              invalid;
        logic              overflow;
    } fpa_out_t;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
    import fpa_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              flip,
    output fpa_op_t           op
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f   = word[WORD_W-2:FRAC_W];
        frac_f  = word[FRAC_W-1:0];
        op.sign = word[WORD_W-1] ^ flip;
        op.exp  = exp_f;
        op.zero = (exp_f == '0);
        op.inf  = (exp_f == '1) && (frac_f == '0);
        op.nan  = (exp_f == '1) && (frac_f != '0);
        op.sig  = op.zero ? '0 : {1'b1, frac_f};
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
(
    input  fpa_op_t          op_x,
    input  fpa_op_t          op_y,
    output logic             big_sign,
    output logic [EXP_W-1:0] big_exp,
    output logic [EXT_W-1:0] big_x,
    output logic [EXT_W-1:0] small_x,
    output logic             eff_sub
);
    localparam int PAD    = EXT_W;
    localparam int SHW_W  = SIG_W + 2;
    localparam int WIDE_W = SHW_W + PAD;

    fpa_op_t            big_op, small_op;
    logic [EXP_W-1:0]   diff;
    logic [EXP_W-1:0]   shamt;
    logic [WIDE_W-1:0]  wide;

    always_comb begin
        if ({op_x.exp, op_x.sig} >= {op_y.exp, op_y.sig}) begin
            big_op   = op_x;
            small_op = op_y;
        end else begin
            big_op   = op_y;
            small_op = op_x;
        end
        diff  = big_op.exp - small_op.exp;
        shamt = (diff > EXP_W'(PAD)) ? EXP_W'(PAD) : diff;
        wide  = {small_op.sig, 2'b00, {PAD{1'b0}}} >> shamt;

        big_sign = big_op.sign;
        big_exp  = big_op.exp;
        big_x    = {big_op.sig, 3'b000};
        small_x  = {wide[WIDE_W-1 -: SHW_W], |wide[PAD-1:0]};
        eff_sub  = op_x.sign ^ op_y.sign;
    end
endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round
    import fpa_pkg::*;
(
    input  logic              big_sign,
    input  logic [EXP_W-1:0]  big_exp,
    input  logic [EXT_W-1:0]  big_x,
    input  logic [EXT_W-1:0]  small_x,
    input  logic              eff_sub,
    output logic [WORD_W-1:0] word,
    output logic              overflow
);
    logic [EXT_W:0]   sum;
    logic [EXT_W-1:0] norm;
    logic [LZ_W-1:0]  lz;
    logic [SIG_W-1:0] mant;
    logic [SIG_W:0]   mant_r;
    logic [SIG_W-1:0] mant_f;
    logic             grd, rnd, stk, up;
    int               e_i;

    always_comb begin
        sum = eff_sub ? ({1'b0, big_x} - {1'b0, small_x})
                      : ({1'b0, big_x} + {1'b0, small_x});

        lz = '0;
        for (int i = 0; i < EXT_W; i++) begin
            if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
        end

        if (sum[EXT_W]) begin
            norm = {sum[EXT_W:2], sum[1] | sum[0]};
            e_i  = int'(big_exp) + 1;
        end else begin
            norm = sum[EXT_W-1:0] << lz;
            e_i  = int'(big_exp) - int'(lz);
        end

        mant   = norm[EXT_W-1:3];
        grd    = norm[2];
        rnd    = norm[1];
        stk    = norm[0];
        up     = grd & (rnd | stk | mant[0]);
        mant_r = {1'b0, mant} + {{SIG_W{1'b0}}, up};
        if (mant_r[SIG_W]) begin
            mant_f = mant_r[SIG_W:1];
            e_i    = e_i + 1;
        end else begin
            mant_f = mant_r[SIG_W-1:0];
        end

        overflow = 1'b0;
        if (sum == '0) begin
            word = {~eff_sub & big_sign, {(WORD_W-1){1'b0}}};
        end else if (e_i <= 0) begin
            word = {big_sign, {(WORD_W-1){1'b0}}};
        end else if (e_i >= EXP_MAX) begin
            word     = {big_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            overflow = 1'b1;
        end else begin
            word = {big_sign, EXP_W'(e_i), mant_f[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp
    import fpa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        sub_sel,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        flag_invalid,
    output logic        flag_overflow
);
    logic [WORD_W-1:0] in_w [2];
    fpa_op_t           ops  [2];

    assign in_w[0] = op_a;
    assign in_w[1] = op_b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpa_unpack u_unpack (
            .word (in_w[gi]),
            .flip ((gi == 1) ? sub_sel : 1'b0),
            .op   (ops[gi])
        );
    end

    logic              al_sign, al_sub;
    logic [EXP_W-1:0]  al_exp;
    logic [EXT_W-1:0]  al_big, al_small;
    logic [WORD_W-1:0] nr_word;
    logic              nr_ovf;

    fpa_align u_align (
        .op_x     (ops[0]),
        .op_y     (ops[1]),
        .big_sign (al_sign),
        .big_exp  (al_exp),
        .big_x    (al_big),
        .small_x  (al_small),
        .eff_sub  (al_sub)
    );

    fpa_norm_round u_norm (
        .big_sign (al_sign),
        .big_exp  (al_exp),
        .big_x    (al_big),
        .small_x  (al_small),
        .eff_sub  (al_sub),
        .word     (nr_word),
        .overflow (nr_ovf)
    );

    localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    fpa_out_t out_d, out_q;

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.valid = 1'b1;
            if (ops[0].nan || ops[1].nan) begin
                out_d.word = QNAN_WORD;
            end else if (ops[0].inf && ops[1].inf) begin
                if (ops[0].sign != ops[1].sign) begin
                    out_d.word    = QNAN_WORD;
                    out_d.invalid = 1'b1;
                end else begin
                    out_d.word = {ops[0].sign, INF_MAG};
                end
            end else if (ops[0].inf) begin
                out_d.word = {ops[0].sign, INF_MAG};
            end else if (ops[1].inf) begin
                out_d.word = {ops[1].sign, INF_MAG};
            end else begin
                out_d.word     = nr_word;
                out_d.overflow = nr_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid     = out_q.valid;
    assign result        = out_q.word;
    assign flag_invalid  = out_q.invalid;
    assign flag_overflow = out_q.overflow;
endmodule

// File: rtl/fp_add_sp_chk.sv
module fp_add_sp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        sub_sel,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_invalid,
    input logic        flag_overflow
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (result == 32'h0 && !flag_invalid && !flag_overflow));
    // R7
    no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(result[30:23] == 8'h00 && result[22:0] != 23'h0));
    // R8
    nan_prop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((op_a[30:23] == 8'hFF && op_a[22:0] != 0) ||
                      (op_b[30:23] == 8'hFF && op_b[22:0] != 0)))
        |=> (result == 32'h7FC00000 && !flag_overflow));
    // R9
    invalid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result == 32'h7FC00000 && !flag_overflow));
    // R10
    overflow_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (result[30:0] == 31'h7F800000));
endmodule

bind fp_add_sp fp_add_sp_chk u_chk (.*);

// File: tb/fp_add_sp_tb.sv
module fp_add_sp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_invalid;
    logic        flag_overflow;

    always #2.5 clk = ~clk;

    fp_add_sp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow)
    );

    typedef struct packed {
        logic [31:0] word;
        logic        inv;
        logic        ovf;
        logic [23:0] tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic [31:0] w,
                         input logic inv, input logic ovf, input logic [23:0] tag);
        @(negedge clk);
        in_valid = 1'b1; sub_sel = s; op_a = a; op_b = b;
        exp_q.push_back('{word: w, inv: inv, ovf: ovf, tag: tag});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; sub_sel = 1'b0; op_a = '0; op_b = '0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected result got=%h expected=none", result);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (result !== e.word || flag_invalid !== e.inv || flag_overflow !== e.ovf) begin
                        failures++;
                        $display("FAIL %s got=%h inv=%b ovf=%b expected=%h inv=%b ovf=%b",
                                 e.tag, result, flag_invalid, flag_overflow, e.word, e.inv, e.ovf);
                    end
                end
            end else if (result !== 32'h0 || flag_invalid || flag_overflow) begin
                checks++;
                failures++;
                $display("FAIL R1 idle outputs got=%h expected=00000000", result);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (out_valid !== 1'b0 || result !== 32'h0 || flag_invalid !== 1'b0 || flag_overflow !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset got=%b/%h expected=0/00000000", out_valid, result);
        end
        rst_n = 1'b1;
        idle(2);
        // R2 plain sums, including large exponent difference
        issue(32'h3F800000, 32'h3F800000, 0, 32'h40000000, 0, 0, "R2 ");
        issue(32'h3F800000, 32'h40000000, 0, 32'h40400000, 0, 0, "R2 ");
        issue(32'h3F800000, 32'h0C000000, 0, 32'h3F800000, 0, 0, "R2 ");
        // R3 subtraction select
        issue(32'h40400000, 32'h3F800000, 1, 32'h40000000, 0, 0, "R3 ");
        issue(32'h3F800000, 32'h40400000, 1, 32'hC0000000, 0, 0, "R3 ");
        idle(2);
        // R4 ties and above-half
        issue(32'h3F800000, 32'h33800000, 0, 32'h3F800000, 0, 0, "R4 ");
        issue(32'h3F800001, 32'h33800000, 0, 32'h3F800002, 0, 0, "R4 ");
        issue(32'h3F800000, 32'h33800001, 0, 32'h3F800001, 0, 0, "R4 ");
        // R5 rounding carry
        issue(32'h3FFFFFFF, 32'h33800000, 0, 32'h40000000, 0, 0, "R5 ");
        // R6 cancellation and exact zero
        issue(32'h3F800001, 32'h3F800000, 1, 32'h34000000, 0, 0, "R6 ");
        issue(32'h3F800000, 32'h3F800000, 1, 32'h00000000, 0, 0, "R6 ");
        issue(32'hBF800000, 32'h3F800000, 0, 32'h00000000, 0, 0, "R6 ");
        issue(32'h3F800000, 32'h33800001, 1, 32'h3F7FFFFF, 0, 0, "R6 ");
        idle(1);
        // R7 zero exponent fields and underflow flush
        issue(32'h00000001, 32'h3F800000, 0, 32'h3F800000, 0, 0, "R7 ");
        issue(32'h00800001, 32'h00800000, 1, 32'h00000000, 0, 0, "R7 ");
        // R8 NaN
        issue(32'h7F800001, 32'h3F800000, 0, 32'h7FC00000, 0, 0, "R8 ");
        issue(32'h3F800000, 32'hFFC12345, 1, 32'h7FC00000, 0, 0, "R8 ");
        // R9 infinities
        issue(32'h7F800000, 32'h3F800000, 0, 32'h7F800000, 0, 0, "R9 ");
        issue(32'h7F800000, 32'h7F800000, 1, 32'h7FC00000, 1, 0, "R9 ");
        issue(32'hFF800000, 32'h7F800000, 0, 32'h7FC00000, 1, 0, "R9 ");
        issue(32'h3F800000, 32'h7F800000, 1, 32'hFF800000, 0, 0, "R9 ");
        // R10 overflow
        issue(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 32'h7F800000, 0, 1, "R10");
        issue(32'hFF7FFFFF, 32'hFF7FFFFF, 0, 32'hFF800000, 0, 1, "R10");
        idle(4);
        checks++; // R1 every queued result delivered
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 missing results got=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL R1 watchdog got=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule